// File: doc/BRIEF.md
# Serial Compressed-Stream Input Receiver

This block takes a compressed audio bitstream delivered over a two-wire serial link: a bit clock and a data line, with no frame or word clock. Both wires are brought into the core clock domain through a synchronizer. Each rising edge of the bit clock captures one data bit. Bits are packed most-significant-first into bytes, and every completed byte is written into an internal byte FIFO. The decoder core drains that FIFO from its own side with a read strobe. A show-ahead output always presents the oldest stored byte.

Because the link carries no framing, the sender paces itself only by a request line. The block raises this line when FIFO occupancy drops below a programmable low-water mark. It drops the line once occupancy climbs above a programmable high-water mark, and holds it in between, so the request has hysteresis. Two sticky flags record abnormal events. The overflow flag is set when a byte completes while the FIFO is full; that byte is discarded. The underflow flag is set when the consumer reads while the FIFO is empty.

Top module: `ssr_stream_rx`

## Requirements
- R1: While reset is high and on the first cycle after it, `level` is 0, `empty` is 1, `req` is 1, and both `ovf_flag` and `unf_flag` are 0.
- R2: A data bit is taken only on a rising edge of `ser_clk`. Data changes while `ser_clk` is high or falling do not alter the captured value. Bits fill a byte starting at bit 7 (the first bit received) down to bit 0.
- R3: Bytes leave the FIFO in arrival order. While `empty` is 0, `rd_data` shows the oldest byte. A cycle with `rd_en` high and `empty` 0 removes that byte.
- R4: `level` equals the number of stored bytes, from 0 up to DEPTH, and `empty` is 1 exactly when `level` is 0.
- R5: A byte that completes while `level` equals DEPTH is dropped: the stored contents and `level` are unchanged, and `ovf_flag` becomes 1.
- R6: A read strobe while the FIFO is empty leaves `level` at 0 and sets `unf_flag` to 1.
- R7: One cycle after any cycle in which `level` is below `low_mark`, `req` is 1.
- R8: One cycle after any cycle in which `level` is above `high_mark` and not below `low_mark`, `req` is 0. With `level` between the marks (inclusive), `req` keeps its value.
- R9: `ovf_flag` and `unf_flag` stay set until reset once they have been set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial bit clock from the sender (asynchronous) |
| ser_dat | input | 1 | Serial data, valid around rising edges of `ser_clk` |
| rd_en | input | 1 | Consumer read strobe |
| low_mark | input | LW | Occupancy below which the request is raised |
| high_mark | input | LW | Occupancy above which the request is dropped |
| rd_data | output | 8 | Oldest stored byte (show-ahead) |
| level | output | LW | Current FIFO occupancy |
| empty | output | 1 | FIFO holds no bytes |
| req | output | 1 | Request for more data toward the sender |
| ovf_flag | output | 1 | Sticky overflow indicator |
| unf_flag | output | 1 | Sticky underflow indicator |

## Verification
A rising edge on `ser_clk` reaches the edge detector two core cycles later, after the two synchronizer flops. The assembled byte is registered on the next edge. `level`, `rd_data` and the overflow flag change one cycle after that. `req` follows one further cycle later. A read strobe changes `level`, `rd_data` and the underflow flag one cycle after the strobe, and `req` one cycle after that. The bench holds each serial half-bit for several core cycles. It samples on falling core-clock edges only after at least eight core cycles have passed since the last stimulus, which is past every one of these delays. The bench model therefore advances exactly one step per byte or read.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

    typedef logic [7:0] byte_t;

    typedef struct packed {
        logic  valid;
        byte_t data;
    } byte_beat_t;

    typedef enum logic {
        REQ_HOLD_OFF = 1'b0,
        REQ_ASKING   = 1'b1
    } req_state_t;

    // Wrap-around pointer increment for a buffer of any depth
    function automatic int unsigned ptr_step(input int unsigned ptr, input int unsigned depth);
        return (ptr == depth - 1) ? 0 : ptr + 1;
    endfunction

endpackage

// File: rtl/ssr_bit_sampler.sv
module ssr_bit_sampler
    import ssr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ser_clk,
    input  logic       ser_dat,
    output byte_beat_t beat
);
    logic [SYNC_STAGES-1:0] clk_sync;
    logic [SYNC_STAGES-1:0] dat_sync;
    logic                   clk_prev;
    logic [6:0]             partial;
    logic [2:0]             bit_cnt;
    logic                   rise;
    logic                   bit_now;

    // Both wires go through identical delay so data stays aligned with its edge
    always_ff @(posedge clk) begin
        if (rst) begin
            clk_sync <= '0;
            dat_sync <= '0;
        end else begin
            clk_sync <= {clk_sync[SYNC_STAGES-2:0], ser_clk};
            dat_sync <= {dat_sync[SYNC_STAGES-2:0], ser_dat};
        end
    end

    assign rise    = clk_sync[SYNC_STAGES-1] & ~clk_prev;
    assign bit_now = dat_sync[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_prev <= 1'b0;
            partial  <= '0;
            bit_cnt  <= '0;
            beat     <= '0;
        end else begin
            clk_prev   <= clk_sync[SYNC_STAGES-1];
            beat.valid <= 1'b0;
            if (rise) begin
                partial <= {partial[5:0], bit_now};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    beat.valid <= 1'b1;
                    beat.data  <= {partial, bit_now};
                end
            end
        end
    end
endmodule

// File: rtl/ssr_byte_fifo.sv
module ssr_byte_fifo
    import ssr_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  byte_beat_t    wr_beat,
    input  logic          rd_en,
    output byte_t         rd_data,
    output logic [LW-1:0] count,
    output logic          ovf,
    output logic          unf
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    byte_t         store [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          is_full;
    logic          is_empty;
    logic          push_ok;
    logic          pop_ok;

    assign is_full  = (count == LW'(DEPTH));
    assign is_empty = (count == '0);
    assign push_ok  = wr_beat.valid & ~is_full;
    assign pop_ok   = rd_en & ~is_empty;
    assign rd_data  = store[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) store[wr_ptr] <= wr_beat.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
            unf    <= 1'b0;
        end else begin
            if (push_ok) wr_ptr <= AW'(ptr_step(int'(wr_ptr), DEPTH));
            if (pop_ok)  rd_ptr <= AW'(ptr_step(int'(rd_ptr), DEPTH));
            count <= count + LW'(push_ok) - LW'(pop_ok);
            if (wr_beat.valid && is_full) ovf <= 1'b1;
            if (rd_en && is_empty)        unf <= 1'b1;
        end
    end
endmodule

// File: rtl/ssr_req_ctrl.sv
module ssr_req_ctrl
    import ssr_pkg::*;
#(
    parameter int LW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [LW-1:0] count,
    input  logic [LW-1:0] low_mark,
    input  logic [LW-1:0] high_mark,
    output logic          req
);
    req_state_t state;

    // Low-water test wins over the high-water test
    always_ff @(posedge clk) begin
        if (rst)                     state <= REQ_ASKING;
        else if (count < low_mark)   state <= REQ_ASKING;
        else if (count > high_mark)  state <= REQ_HOLD_OFF;
    end

    assign req = (state == REQ_ASKING);
endmodule

// File: rtl/ssr_stream_rx.sv
module ssr_stream_rx
    import ssr_pkg::*;
#(
    parameter int DEPTH       = 1024,
    parameter int SYNC_STAGES = 2,
    parameter int LW          = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ser_clk,
    input  logic          ser_dat,
    input  logic          rd_en,
    input  logic [LW-1:0] low_mark,
    input  logic [LW-1:0] high_mark,
    output logic [7:0]    rd_data,
    output logic [LW-1:0] level,
    output logic          empty,
    output logic          req,
    output logic          ovf_flag,
    output logic          unf_flag
);
    byte_beat_t beat;
    logic       byte_push;

    ssr_bit_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk     (clk),
        .rst     (rst),
        .ser_clk (ser_clk),
        .ser_dat (ser_dat),
        .beat    (beat)
    );

    ssr_byte_fifo #(.DEPTH(DEPTH), .LW(LW)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_beat (beat),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .count   (level),
        .ovf     (ovf_flag),
        .unf     (unf_flag)
    );

    ssr_req_ctrl #(.LW(LW)) u_req (
        .clk       (clk),
        .rst       (rst),
        .count     (level),
        .low_mark  (low_mark),
        .high_mark (high_mark),
        .req       (req)
    );

    assign byte_push = beat.valid;
    assign empty     = (level == '0);
endmodule

// File: rtl/ssr_stream_rx_chk.sv
module ssr_stream_rx_chk #(
    parameter int DEPTH = 1024,
    parameter int LW    = 11
) (
    input logic          clk,
    input logic          rst,
    input logic          rd_en,
    input logic          byte_push,
    input logic [LW-1:0] low_mark,
    input logic [LW-1:0] high_mark,
    input logic [LW-1:0] level,
    input logic          req,
    input logic          ovf_flag,
    input logic          unf_flag
);
    assert_level_bound_R4: assert property (@(posedge clk) disable iff (rst)
        level <= LW'(DEPTH));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        (byte_push && level == LW'(DEPTH) && !rd_en) |=> (level == LW'(DEPTH) && ovf_flag));

    assert_underflow_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && level == '0 && !byte_push) |=> (level == '0 && unf_flag));

    assert_req_low_R7: assert property (@(posedge clk) disable iff (rst)
        (level < low_mark) |=> req);

    assert_req_high_R8: assert property (@(posedge clk) disable iff (rst)
        (level > high_mark && !(level < low_mark)) |=> !req);

    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        ovf_flag |=> ovf_flag);

    assert_unf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        unf_flag |=> unf_flag);
endmodule

bind ssr_stream_rx ssr_stream_rx_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en),
    .byte_push (byte_push),
    .low_mark  (low_mark),
    .high_mark (high_mark),
    .level     (level),
    .req       (req),
    .ovf_flag  (ovf_flag),
    .unf_flag  (unf_flag)
);

// File: tb/ssr_stream_rx_test.sv
module ssr_stream_rx_test;
    localparam int DEPTH = 32;
    localparam int LW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ser_clk = 1'b0;
    logic          ser_dat = 1'b0;
    logic          rd_en = 1'b0;
    logic [LW-1:0] low_mark = LW'(8);
    logic [LW-1:0] high_mark = LW'(20);
    logic [7:0]    rd_data;
    logic [LW-1:0] level;
    logic          empty;
    logic          req;
    logic          ovf_flag;
    logic          unf_flag;

    int checks = 0;
    int fails  = 0;

    logic [7:0] mq[$];
    bit         m_req;
    bit         m_ovf;
    bit         m_unf;

    always #4 clk = ~clk;

    ssr_stream_rx #(.DEPTH(DEPTH)) uut (
        .clk, .rst, .ser_clk, .ser_dat, .rd_en, .low_mark, .high_mark,
        .rd_data, .level, .empty, .req, .ovf_flag, .unf_flag
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit next_req(input bit cur, input int lvl, input int lo, input int hi);
        if (lvl < lo) return 1'b1;
        if (lvl > hi) return 1'b0;
        return cur;
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One byte, MSB first; data is disturbed during the high phase (R2)
    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            ser_dat = b[i];
            idle(3);
            ser_clk = 1'b1;
            idle(2);
            ser_dat = ~b[i];
            idle(1);
            ser_clk = 1'b0;
        end
        idle(8);
        if (mq.size() < DEPTH) mq.push_back(b);
        else m_ovf = 1'b1;
        m_req = next_req(m_req, mq.size(), int'(low_mark), int'(high_mark));
    endtask

    task automatic pop_one();
        rd_en = 1'b1;
        idle(1);
        rd_en = 1'b0;
        idle(8);
        if (mq.size() == 0) m_unf = 1'b1;
        else void'(mq.pop_front());
        m_req = next_req(m_req, mq.size(), int'(low_mark), int'(high_mark));
    endtask

    task automatic check_state(input string tag);
        check({tag, " R4 level"}, int'(level), mq.size());
        check({tag, " R4 empty"}, int'(empty), int'(mq.size() == 0));
        if (mq.size() != 0) check({tag, " R3 rd_data"}, int'(rd_data), int'(mq[0]));
        check({tag, " R7/R8 req"}, int'(req), int'(m_req));
        check({tag, " R9 ovf"}, int'(ovf_flag), int'(m_ovf));
        check({tag, " R9 unf"}, int'(unf_flag), int'(m_unf));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle(4);
        rst = 1'b0;
        mq.delete();
        m_req = 1'b1;
        m_ovf = 1'b0;
        m_unf = 1'b0;
    endtask

    initial begin
        #1_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset();
        idle(1);
        // R1: reset state
        check("R1 level", int'(level), 0);
        check("R1 empty", int'(empty), 1);
        check("R1 req", int'(req), 1);
        check("R1 ovf", int'(ovf_flag), 0);
        check("R1 unf", int'(unf_flag), 0);

        // R2: MSB-first assembly, rising edge only
        send_byte(8'hA5);
        check("R2 first byte", int'(rd_data), 8'hA5);
        send_byte(8'h3C);
        check_state("R2 two bytes");

        // Random mix of arrivals and reads (R3, R4, R7, R8)
        for (int k = 0; k < 80; k++) begin
            if (($urandom % 10) < 6 && mq.size() < DEPTH) send_byte(8'($urandom));
            else if (mq.size() > 0) pop_one();
            check_state("random");
        end

        // Drain, then read on empty (R6)
        while (mq.size() > 0) pop_one();
        pop_one();
        check("R6 level stays 0", int'(level), 0);
        check("R6 unf set", int'(unf_flag), 1);

        // Fill to full, then one extra byte (R4, R5)
        for (int k = 0; k < DEPTH; k++) send_byte(8'(k * 7 + 1));
        check("R4 full level", int'(level), DEPTH);
        send_byte(8'hEE);
        check("R5 level unchanged", int'(level), DEPTH);
        check("R5 ovf set", int'(ovf_flag), 1);
        check("R5 front unchanged", int'(rd_data), 1);
        while (mq.size() > 0) begin
            check("R3/R5 drain order", int'(rd_data), int'(mq[0]));
            pop_one();
        end
        check("R5 dropped byte absent", int'(level), 0);
        send_byte(8'h5A);
        // R9: flags persist through later traffic
        check_state("R9 after traffic");

        // Hysteresis with close marks (R7, R8)
        low_mark  = LW'(4);
        high_mark = LW'(6);
        do_reset();
        idle(1);
        check_state("R1 after second reset");
        for (int k = 0; k < 6; k++) send_byte(8'(k));
        check("R8 at high mark still asking", int'(req), 1);
        send_byte(8'h77);
        check("R8 above high mark", int'(req), 0);
        pop_one();
        pop_one();
        check("R8 between marks holds", int'(req), 0);
        pop_one();
        pop_one();
        check("R7 below low mark", int'(req), 1);
        send_byte(8'h11);
        send_byte(8'h22);
        check("R8 between marks holds asking", int'(req), 1);
        check_state("hysteresis end");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule